// File: doc/BRIEF.md
# Open-Page DRAM Read Sequencer

This block turns single read requests into the command sequence of one DRAM bank and streams the resulting burst back to the requester. It leaves the last activated row open. A request that targets that same row goes straight to a column read. A request for another row first closes the open row, then opens the new one, then reads. When no row is open, which is the state after reset, the close step is skipped.

Every spacing between commands is counted in clock cycles against four timing inputs. Three of them are lower bounds: precharge to activate, activate to read, and activate to the next precharge. The fourth, read to first data, is an exact latency. Each command is placed in the earliest cycle its bounds allow. A read returns eight 64-bit beats on consecutive cycles. Each beat is the eight bank byte lanes placed side by side, and the beats come from eight consecutive columns starting at a burst-aligned column.

The requester sees a valid/ready port that takes one request at a time. It also receives a per-beat valid, a last flag and a row-hit flag, so that it can tell which of the two latency classes a request fell into.

Top module: `dram_page_seq`

## Requirements
- R1: After reset no row is open, `reqReady` is 1, `cmdPre`, `cmdAct`, `cmdRd` and `rspValid` are 0, and at most one of the three command strobes is 1 in any cycle.
- R2: A request is accepted in a cycle where `reqValid` and `reqReady` are both 1. `reqReady` is 0 from the cycle after acceptance through the cycle of the last beat, and it is 1 again in the cycle after the last beat.
- R3: `reqAddr` is split as {row, column}, with the row in the upper `ROW_W` bits. The low three column bits are a beat offset and are ignored. `cmdRow` carries the row during activate, and `cmdCol` carries the column with its low three bits cleared during the read.
- R4: A request whose row equals the open row issues no precharge or activate, and issues the read in the cycle after acceptance.
- R5: A request that arrives while no row is open issues no precharge, and issues the activate in the cycle after acceptance.
- R6: A request for a different row while a row is open issues precharge in cycle max(q+1, A+tRas), where q is the acceptance cycle and A is the cycle of the last activate. The activate follows exactly tRp cycles after the precharge.
- R7: The read is issued exactly tRcd cycles after the activate of a missed request.
- R8: The first beat is presented exactly tCl cycles after the read cycle. Its data is `memLane` as seen in that same cycle.
- R9: A burst has eight beats on consecutive cycles. Beat i carries the data of column (aligned column + i). `rspLast` is 1 only on the eighth beat.
- R10: The timing inputs `tRp`, `tRcd`, `tCl` and `tRas` are programmable, each at least 1. Values changed while the block is idle govern all later requests.
- R11: `rspHit` is 1 on every beat of a request that met the open row and 0 on every beat of a missed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tRp | input | TW | Minimum precharge-to-activate cycles |
| tRcd | input | TW | Minimum activate-to-read cycles |
| tCl | input | TW | Exact read-to-first-beat cycles |
| tRas | input | TW | Minimum activate-to-precharge cycles |
| reqValid | input | 1 | Read request valid |
| reqAddr | input | ROW_W+COL_W | Request address {row, column} |
| reqReady | output | 1 | Sequencer can accept a request |
| cmdPre | output | 1 | Precharge command strobe |
| cmdAct | output | 1 | Activate command strobe |
| cmdRd | output | 1 | Column read command strobe |
| cmdRow | output | ROW_W | Row address for activate |
| cmdCol | output | COL_W | Burst-aligned column for read |
| memLane | input | NBANK*BYTE_W | Byte lanes of all banks, bank b at bits [8b+7:8b] |
| rspValid | output | 1 | Response beat valid |
| rspLast | output | 1 | Eighth beat of the burst |
| rspHit | output | 1 | Request met the open row |
| rspData | output | NBANK*BYTE_W | Response beat |

## Verification
Two rules can fall due in the same cycle. One is the expiry of the activate-to-precharge window. The other is the precharge slot that directly follows accepting a miss. The bench provokes this by holding the bus idle until acceptance lands exactly one cycle before the window closes, and also by sending the miss straight after the previous burst, which lands one cycle earlier. It then judges whether precharge appears in the very next cycle in the first case and one cycle later in the second. A second overlap is the last beat followed at once by a new request. This is judged by the new request being accepted in the cycle right after that beat.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WRAS,
    S_PRE,
    S_WRP,
    S_ACT,
    S_WRCD,
    S_RD,
    S_WCL,
    S_DATA
  } seq_state_e;

  typedef struct packed {
    logic latchReq;
    logic issuePre;
    logic issueAct;
    logic issueRd;
    logic beatValid;
    logic beatLast;
  } seq_strobe_t;

endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int TW    = 8,
  parameter int BURST = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          rowOpen,
  input  logic          rowHit,
  input  logic [TW-1:0] tRp,
  input  logic [TW-1:0] tRcd,
  input  logic [TW-1:0] tCl,
  input  logic [TW-1:0] tRas,
  output logic          reqReady,
  output seq_strobe_t   stb
);

  localparam int BW = $clog2(BURST);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BURST - 1);

  seq_state_e    state, nextState;
  logic [TW-1:0] gapCnt;
  logic [TW-1:0] rasCnt;
  logic [BW-1:0] beatCnt;
  logic          inCmd;
  logic [TW-1:0] elapsed;

  // True when the next cycle is at least lim cycles after the last event
  function automatic logic reached(input logic [TW-1:0] since, input logic [TW-1:0] lim);
    return ({1'b0, since} + (TW+1)'(1)) >= {1'b0, lim};
  endfunction

  assign inCmd   = (state == S_PRE) || (state == S_ACT) || (state == S_RD);
  assign elapsed = inCmd ? '0 : gapCnt;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (!rowOpen)                nextState = S_ACT;
          else if (rowHit)             nextState = S_RD;
          else if (reached(rasCnt, tRas)) nextState = S_PRE;
          else                         nextState = S_WRAS;
        end
      end
      S_WRAS: if (reached(rasCnt, tRas)) nextState = S_PRE;
      S_PRE:  nextState = reached(elapsed, tRp) ? S_ACT : S_WRP;
      S_WRP:  if (reached(elapsed, tRp)) nextState = S_ACT;
      S_ACT:  nextState = reached(elapsed, tRcd) ? S_RD : S_WRCD;
      S_WRCD: if (reached(elapsed, tRcd)) nextState = S_RD;
      S_RD:   nextState = reached(elapsed, tCl) ? S_DATA : S_WCL;
      S_WCL:  if (reached(elapsed, tCl)) nextState = S_DATA;
      S_DATA: if (beatCnt == LAST_BEAT) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      gapCnt  <= '0;
      rasCnt  <= '1;
      beatCnt <= '0;
    end else begin
      state <= nextState;

      if (inCmd)               gapCnt <= TW'(1);
      else if (gapCnt != '1)   gapCnt <= gapCnt + TW'(1);

      if (state == S_ACT)      rasCnt <= TW'(1);
      else if (rasCnt != '1)   rasCnt <= rasCnt + TW'(1);

      if (state == S_DATA)     beatCnt <= (beatCnt == LAST_BEAT) ? '0 : beatCnt + BW'(1);
      else                     beatCnt <= '0;
    end
  end

  assign reqReady      = (state == S_IDLE);
  assign stb.latchReq  = (state == S_IDLE) && reqValid;
  assign stb.issuePre  = (state == S_PRE);
  assign stb.issueAct  = (state == S_ACT);
  assign stb.issueRd   = (state == S_RD);
  assign stb.beatValid = (state == S_DATA);
  assign stb.beatLast  = (state == S_DATA) && (beatCnt == LAST_BEAT);

endmodule

// File: rtl/dram_seq_dpath.sv
module dram_seq_dpath
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int NBANK  = 8,
  parameter int BYTE_W = 8,
  parameter int BURST  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ROW_W+COL_W-1:0]  reqAddr,
  input  seq_strobe_t             stb,
  input  logic [NBANK*BYTE_W-1:0] memLane,
  output logic                    rowOpen,
  output logic                    rowHit,
  output logic                    cmdPre,
  output logic                    cmdAct,
  output logic                    cmdRd,
  output logic [ROW_W-1:0]        cmdRow,
  output logic [COL_W-1:0]        cmdCol,
  output logic                    rspValid,
  output logic                    rspLast,
  output logic                    rspHit,
  output logic [NBANK*BYTE_W-1:0] rspData
);

  localparam int AW = ROW_W + COL_W;
  localparam logic [COL_W-1:0] OFF_MASK = COL_W'(BURST - 1);

  logic [ROW_W-1:0] reqRow;
  logic [COL_W-1:0] reqCol;
  logic [ROW_W-1:0] openRow;
  logic [ROW_W-1:0] pendRow;
  logic [COL_W-1:0] pendCol;
  logic             openValid;
  logic             hitReg;

  assign reqRow = reqAddr[AW-1:COL_W];
  assign reqCol = reqAddr[COL_W-1:0];

  assign rowOpen = openValid;
  assign rowHit  = openValid && (reqRow == openRow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openRow   <= '0;
      openValid <= 1'b0;
      pendRow   <= '0;
      pendCol   <= '0;
      hitReg    <= 1'b0;
    end else begin
      if (stb.latchReq) begin
        pendRow <= reqRow;
        pendCol <= reqCol & ~OFF_MASK;
        hitReg  <= rowHit;
      end
      if (stb.issuePre) openValid <= 1'b0;
      if (stb.issueAct) begin
        openValid <= 1'b1;
        openRow   <= pendRow;
      end
    end
  end

  assign cmdPre   = stb.issuePre;
  assign cmdAct   = stb.issueAct;
  assign cmdRd    = stb.issueRd;
  assign cmdRow   = pendRow;
  assign cmdCol   = pendCol;
  assign rspValid = stb.beatValid;
  assign rspLast  = stb.beatLast;
  assign rspHit   = hitReg;

  // One byte lane per bank, side by side
  for (genvar g = 0; g < NBANK; g++) begin : g_lane
    assign rspData[g*BYTE_W +: BYTE_W] = stb.beatValid ? memLane[g*BYTE_W +: BYTE_W] : '0;
  end

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int NBANK  = 8,
  parameter int BYTE_W = 8,
  parameter int BURST  = 8,
  parameter int TW     = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [TW-1:0]           tRp,
  input  logic [TW-1:0]           tRcd,
  input  logic [TW-1:0]           tCl,
  input  logic [TW-1:0]           tRas,
  input  logic                    reqValid,
  input  logic [ROW_W+COL_W-1:0]  reqAddr,
  output logic                    reqReady,
  output logic                    cmdPre,
  output logic                    cmdAct,
  output logic                    cmdRd,
  output logic [ROW_W-1:0]        cmdRow,
  output logic [COL_W-1:0]        cmdCol,
  input  logic [NBANK*BYTE_W-1:0] memLane,
  output logic                    rspValid,
  output logic                    rspLast,
  output logic                    rspHit,
  output logic [NBANK*BYTE_W-1:0] rspData
);

  seq_strobe_t stb;
  logic        rowOpen;
  logic        rowHit;

  dram_seq_ctrl #(.TW(TW), .BURST(BURST)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .rowOpen (rowOpen),
    .rowHit  (rowHit),
    .tRp     (tRp),
    .tRcd    (tRcd),
    .tCl     (tCl),
    .tRas    (tRas),
    .reqReady(reqReady),
    .stb     (stb)
  );

  dram_seq_dpath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .NBANK(NBANK), .BYTE_W(BYTE_W), .BURST(BURST)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .reqAddr (reqAddr),
    .stb     (stb),
    .memLane (memLane),
    .rowOpen (rowOpen),
    .rowHit  (rowHit),
    .cmdPre  (cmdPre),
    .cmdAct  (cmdAct),
    .cmdRd   (cmdRd),
    .cmdRow  (cmdRow),
    .cmdCol  (cmdCol),
    .rspValid(rspValid),
    .rspLast (rspLast),
    .rspHit  (rspHit),
    .rspData (rspData)
  );

endmodule

// File: rtl/dram_page_seq_chk.sv
module dram_page_seq_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic [TW-1:0] tRp,
  input logic [TW-1:0] tRcd,
  input logic [TW-1:0] tCl,
  input logic [TW-1:0] tRas,
  input logic          reqReady,
  input logic          cmdPre,
  input logic          cmdAct,
  input logic          cmdRd,
  input logic          rspValid,
  input logic          rspLast
);

  localparam int CW = 16;

  logic [CW-1:0] sinceAct, sincePre, sinceRd;
  logic          actSeen, preArmed, prevValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct  <= '0;
      sincePre  <= '0;
      sinceRd   <= '0;
      actSeen   <= 1'b0;
      preArmed  <= 1'b0;
      prevValid <= 1'b0;
    end else begin
      sinceAct  <= cmdAct ? CW'(1) : ((sinceAct != '1) ? sinceAct + CW'(1) : sinceAct);
      sincePre  <= cmdPre ? CW'(1) : ((sincePre != '1) ? sincePre + CW'(1) : sincePre);
      sinceRd   <= cmdRd  ? CW'(1) : ((sinceRd  != '1) ? sinceRd  + CW'(1) : sinceRd);
      if (cmdAct) actSeen <= 1'b1;
      if (cmdPre) preArmed <= 1'b1;
      else if (cmdAct) preArmed <= 1'b0;
      prevValid <= rspValid;
    end
  end

  // R1
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdPre, cmdAct, cmdRd}));

  // R6
  pre_after_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdPre |-> (actSeen && sinceAct >= CW'(tRas)));

  // R6
  act_after_rp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAct && preArmed) |-> (sincePre >= CW'(tRp)));

  // R7
  rd_after_rcd_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdRd |-> (actSeen && sinceAct >= CW'(tRcd)));

  // R8
  first_beat_cl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !prevValid) |-> (sinceRd == CW'(tCl)));

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  // R9
  last_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspLast |-> rspValid);

  // R9
  beats_back_to_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspLast) |=> rspValid);

endmodule

bind dram_page_seq dram_page_seq_chk #(.TW(TW)) chk (
  .clk     (clk),
  .rstN    (rstN),
  .tRp     (tRp),
  .tRcd    (tRcd),
  .tCl     (tCl),
  .tRas    (tRas),
  .reqReady(reqReady),
  .cmdPre  (cmdPre),
  .cmdAct  (cmdAct),
  .cmdRd   (cmdRd),
  .rspValid(rspValid),
  .rspLast (rspLast)
);

// File: tb/dram_page_seq_test.sv
module dram_page_seq_test;

  localparam int ROW_W = 12;
  localparam int COL_W = 10;
  localparam int TW    = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [TW-1:0]     tRp = 8'd7, tRcd = 8'd7, tCl = 8'd7, tRas = 8'd24;
  logic              reqValid = 1'b0;
  logic [21:0]       reqAddr = '0;
  logic              reqReady, cmdPre, cmdAct, cmdRd, rspValid, rspLast, rspHit;
  logic [ROW_W-1:0]  cmdRow;
  logic [COL_W-1:0]  cmdCol;
  logic [63:0]       memLane, rspData;

  int  cyc = 0;
  int  total = 0;
  int  bad = 0;
  bit  done = 0;

  bit  tbOpen = 0;
  int  tbRow = 0;
  int  tbAct = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_page_seq uut (
    .clk(clk), .rstN(rstN), .tRp(tRp), .tRcd(tRcd), .tCl(tCl), .tRas(tRas),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .cmdPre(cmdPre), .cmdAct(cmdAct), .cmdRd(cmdRd), .cmdRow(cmdRow), .cmdCol(cmdCol),
    .memLane(memLane), .rspValid(rspValid), .rspLast(rspLast), .rspHit(rspHit),
    .rspData(rspData)
  );

  // Byte stored in bank b at (row, col); lanes placed bank 0 lowest
  function automatic logic [63:0] lanePat(input int row, input int col);
    logic [63:0] v;
    for (int b = 0; b < 8; b++) v[8*b +: 8] = 8'((row * 5) + (col * 3) + (b * 29) + 11);
    return v;
  endfunction

  // Behavioural memory: beat i appears tCl+i cycles after the read cycle
  int mCnt = 0;
  int mRow = 0;
  int mCol = 0;
  always @(posedge clk) begin
    if (!rstN) mCnt <= 0;
    else if (cmdRd) begin
      mCnt <= 1;
      mRow <= int'(cmdRow);
      mCol <= int'(cmdCol);
    end else if (mCnt != 0 && mCnt < 400) mCnt <= mCnt + 1;
    else mCnt <= 0;
  end
  assign memLane = (mCnt >= int'(tCl) && mCnt < int'(tCl) + 8) ?
                   lanePat(mRow, mCol + mCnt - int'(tCl)) : 64'h0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idleUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic doRead(input logic [21:0] addr);
    int row, col, colAl, q, expPre, expAct, expRd, expData;
    int gotPre, gotAct, gotRd, firstBeat, beats, readyHigh, preCount, actCount, guard;
    bit expHit, fin, coldMiss;
    row = int'(addr[21:10]);
    col = int'(addr[9:0]);
    colAl = col & ~7;
    gotPre = -1; gotAct = -1; gotRd = -1; firstBeat = -1;
    beats = 0; readyHigh = 0; preCount = 0; actCount = 0; guard = 0; fin = 0;
    while (!reqReady) @(negedge clk);
    q = cyc;
    expHit = tbOpen && (row == tbRow);
    coldMiss = !tbOpen;
    if (expHit) begin
      expPre = -1; expAct = -1; expRd = q + 1;
    end else if (coldMiss) begin
      expPre = -1; expAct = q + 1; expRd = expAct + int'(tRcd);
    end else begin
      expPre = (q + 1 > tbAct + int'(tRas)) ? q + 1 : tbAct + int'(tRas);
      expAct = expPre + int'(tRp);
      expRd  = expAct + int'(tRcd);
    end
    expData = expRd + int'(tCl);
    reqValid = 1'b1;
    reqAddr  = addr;
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr  = '0;
    while (!fin && guard < 500) begin
      guard++;
      if (reqReady) readyHigh++;
      if (cmdPre) begin preCount++; gotPre = cyc; end
      if (cmdAct) begin
        actCount++; gotAct = cyc;
        check(int'(cmdRow) == row, "R3", "activate row", cmdRow, row);
      end
      if (cmdRd) begin
        gotRd = cyc;
        check(int'(cmdCol) == colAl, "R3", "aligned read column", cmdCol, colAl);
      end
      if (rspValid) begin
        if (beats == 0) firstBeat = cyc;
        check(rspData == lanePat(row, colAl + beats), "R9", "beat data", rspData, lanePat(row, colAl + beats));
        check(rspLast == (beats == 7), "R9", "last flag", rspLast, beats == 7);
        check(rspHit == expHit, "R11", "hit flag", rspHit, expHit);
        check(cyc == firstBeat + beats, "R9", "consecutive beat cycle", cyc, firstBeat + beats);
        beats++;
        if (rspLast) fin = 1;
      end
      @(negedge clk);
    end
    check(beats == 8, "R9", "beat count", beats, 8);
    check(readyHigh == 0, "R2", "ready while busy", readyHigh, 0);
    check(reqReady == 1'b1, "R2", "ready after last beat", reqReady, 1);
    if (expHit) begin
      check(preCount == 0 && actCount == 0, "R4", "no row commands on hit", preCount + actCount, 0);
      check(gotRd == expRd, "R4", "read cycle on hit", gotRd, expRd);
    end else begin
      if (coldMiss) check(preCount == 0, "R5", "no precharge with no open row", preCount, 0);
      else check(gotPre == expPre, "R6", "precharge cycle", gotPre, expPre);
      check(actCount == 1 && gotAct == expAct, (coldMiss ? "R5" : "R6"), "activate cycle", gotAct, expAct);
      check(gotRd == expRd, "R7", "read cycle after activate", gotRd, expRd);
      tbOpen = 1;
      tbRow  = row;
      tbAct  = expAct;
    end
    check(firstBeat == expData, "R8", "first beat cycle", firstBeat, expData);
  endtask

  task automatic testReset;
    check(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    check({cmdPre, cmdAct, cmdRd} == 3'b000, "R1", "commands after reset", {cmdPre, cmdAct, cmdRd}, 0);
    check(rspValid == 1'b0, "R1", "valid after reset", rspValid, 0);
  endtask

  task automatic testColdMiss;
    doRead({12'd5, 10'h013});
  endtask

  task automatic testRasBoundMiss;
    doRead({12'd9, 10'h080});
  endtask

  task automatic testHitTopColumn;
    doRead({12'd9, 10'h3FB});
  endtask

  task automatic testRasEdgeMiss;
    doRead({12'd3, 10'h020});
    idleUntil(tbAct + int'(tRas) - 1);
    doRead({12'd4, 10'h047});
  endtask

  task automatic testLateMiss;
    idleUntil(cyc + 40);
    doRead({12'd700, 10'h1C0});
  endtask

  task automatic testTimingsShort;
    tRp = 8'd2; tRcd = 8'd3; tCl = 8'd1; tRas = 8'd5;
    @(negedge clk);
    check(reqReady == 1'b1, "R10", "idle before new timings", reqReady, 1);
    doRead({12'd11, 10'h00F});
    doRead({12'd11, 10'h200});
    doRead({12'd12, 10'h008});
  endtask

  task automatic testTimingsLongRas;
    tRp = 8'd1; tRcd = 8'd1; tCl = 8'd3; tRas = 8'd30;
    @(negedge clk);
    check(reqReady == 1'b1, "R10", "idle before long window", reqReady, 1);
    doRead({12'd20, 10'h100});
    doRead({12'd21, 10'h108});
    doRead({12'd21, 10'h110});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset;
    testColdMiss;
    testRasBoundMiss;
    testHitTopColumn;
    testRasEdgeMiss;
    testLateMiss;
    testTimingsShort;
    testTimingsLongRas;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule